// File: doc/BRIEF.md
# 16-Bit Timer/Counter with Auto-Reload, Capture and Baud Tick

This block is a 16-bit up-counter for a microcontroller subsystem. It has three operating modes: auto-reload, capture and baud-rate generation. Each cycle it advances either by one core clock or on a falling edge of an external count pin. A 16-bit reload/capture register holds the value that is loaded into the count, or receives a snapshot of the count. A falling edge on an external trigger pin can force a reload or take a snapshot, depending on the mode.

Two sticky flags go to an interrupt controller: an overflow flag and an external-event flag. Software clears each flag with a write-one-to-clear strobe. In baud-rate mode a one-cycle tick pulse is produced on every overflow, for use by a serial port. Software can write the count and the reload/capture register directly.

Top module: `tmr16_reload_capture`

## Requirements
- R1: The mode is decoded from three bits. `cfg_run`=0 means off, and the count and both flags are left untouched by counting or trigger edges. `cfg_baud_sel`=1 with run means baud mode. `cfg_baud_sel`=0 with `cfg_cap_sel`=0 and run means auto-reload. `cfg_baud_sel`=0 with `cfg_cap_sel`=1 and run means capture.
- R2: In auto-reload mode, an increment from 0xFFFF loads the count from `rc_q` and sets `ovf_flag`.
- R3: In auto-reload mode with `cfg_ext_en`=1, a trigger falling edge loads the count from `rc_q` and sets `ext_flag`. When `cfg_ext_en`=0, trigger edges are ignored. A trigger reload takes priority over an increment in the same cycle.
- R4: In capture mode the count wraps from 0xFFFF to 0x0000 and sets `ovf_flag`.
- R5: In capture mode with `cfg_ext_en`=1, a trigger falling edge copies the current count into `rc_q` and sets `ext_flag`. The count keeps incrementing undisturbed. A capture takes priority over a software write to `rc_q`.
- R6: In baud mode an overflow reloads from `rc_q` and raises `baud_tick` for exactly one cycle. `ovf_flag` is never set in this mode. With `cfg_ext_en`=1, trigger edges set `ext_flag` but do not reload.
- R7: With `cfg_src_ext`=0 the count advances once per core clock. With `cfg_src_ext`=1 it advances once per falling edge of `cnt_pin`. Both pins pass through a two-flop synchronizer, so an effect appears on the outputs after the third rising clock edge that follows the pin edge.
- R8: Each flag stays set until its clear strobe is high at a clock edge. A set event in the same cycle as a clear leaves the flag set.
- R9: `cnt_wr_en` loads `cnt_wr_data` into the count and suppresses increment, reload and overflow in that cycle.
- R10: Synchronous reset sets the count, `rc_q`, both flags and `baud_tick` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_run | input | 1 | Run enable |
| cfg_cap_sel | input | 1 | 1 selects capture, 0 selects auto-reload |
| cfg_baud_sel | input | 1 | Baud-rate mode select |
| cfg_ext_en | input | 1 | Enables trigger-pin events |
| cfg_src_ext | input | 1 | 1 counts `cnt_pin` falling edges, 0 counts core clocks |
| cnt_pin | input | 1 | Asynchronous external count pin |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| cnt_wr_en | input | 1 | Software count write strobe |
| cnt_wr_data | input | WIDTH | Software count write value |
| rc_wr_en | input | 1 | Software reload/capture register write strobe |
| rc_wr_data | input | WIDTH | Software reload/capture write value |
| clr_ovf | input | 1 | Write-one-to-clear for the overflow flag |
| clr_ext | input | 1 | Write-one-to-clear for the external flag |
| count_q | output | WIDTH | Live count |
| rc_q | output | WIDTH | Reload/capture register |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external-event flag |
| baud_tick | output | 1 | One-cycle pulse on each baud-mode overflow |

## Verification
The assertions assume that the configuration bits stay steady while a sequence under test runs. They also assume that the pins change far enough apart for the synchronizer to see each level for at least one cycle. The stimulus changes configuration only together with a software write to the count, which masks that cycle. Each pin edge is held for at least two clocks before the opposite edge is driven. Trigger and count edges are placed at known offsets from a software write, so every expected count follows from the three-edge synchronizer latency.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_RELOAD  = 2'd1,
    MODE_CAPTURE = 2'd2,
    MODE_BAUD    = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_fall_detect.sv
module tmr_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Idle-high reset so a pin held high at start produces no edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];

  // R7: a detected edge lasts one cycle only
  a_r7_fall_one_cycle: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/tmr_mode_dec.sv
module tmr_mode_dec
  import tmr_pkg::*;
(
  input  logic      run,
  input  logic      cap_sel,
  input  logic      baud_sel,
  output tmr_mode_e mode
);
  always_comb begin
    if (!run)          mode = MODE_OFF;
    else if (baud_sel) mode = MODE_BAUD;
    else if (cap_sel)  mode = MODE_CAPTURE;
    else               mode = MODE_RELOAD;
  end
endmodule

// File: rtl/tmr16_reload_capture.sv
module tmr16_reload_capture
  import tmr_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_run,
  input  logic             cfg_cap_sel,
  input  logic             cfg_baud_sel,
  input  logic             cfg_ext_en,
  input  logic             cfg_src_ext,
  input  logic             cnt_pin,
  input  logic             trig_pin,
  input  logic             cnt_wr_en,
  input  logic [WIDTH-1:0] cnt_wr_data,
  input  logic             rc_wr_en,
  input  logic [WIDTH-1:0] rc_wr_data,
  input  logic             clr_ovf,
  input  logic             clr_ext,
  output logic [WIDTH-1:0] count_q,
  output logic [WIDTH-1:0] rc_q,
  output logic             ovf_flag,
  output logic             ext_flag,
  output logic             baud_tick
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  tmr_mode_e mode;
  logic cnt_fall, trig_fall;
  logic src_tick, step, wrap;
  logic reload_trig, cap_trig, ext_evt, ovf_evt;

  tmr_mode_dec u_dec (
    .run(cfg_run), .cap_sel(cfg_cap_sel), .baud_sel(cfg_baud_sel), .mode(mode)
  );

  tmr_fall_detect #(.STAGES(SYNC_STAGES)) u_cnt_edge (
    .clk(clk), .rst(rst), .pin(cnt_pin), .fall(cnt_fall)
  );

  tmr_fall_detect #(.STAGES(SYNC_STAGES)) u_trig_edge (
    .clk(clk), .rst(rst), .pin(trig_pin), .fall(trig_fall)
  );

  always_comb begin
    src_tick    = cfg_src_ext ? cnt_fall : 1'b1;
    reload_trig = (mode == MODE_RELOAD)  && cfg_ext_en && trig_fall;
    cap_trig    = (mode == MODE_CAPTURE) && cfg_ext_en && trig_fall;
    ext_evt     = (mode != MODE_OFF)     && cfg_ext_en && trig_fall;
    step        = (mode != MODE_OFF) && src_tick && !cnt_wr_en && !reload_trig;
    wrap        = step && (count_q == CNT_MAX);
    ovf_evt     = wrap && ((mode == MODE_RELOAD) || (mode == MODE_CAPTURE));
  end

  // Count: software write, then trigger reload, then wrap, then increment.
  always_ff @(posedge clk) begin
    if (rst)              count_q <= '0;
    else if (cnt_wr_en)   count_q <= cnt_wr_data;
    else if (reload_trig) count_q <= rc_q;
    else if (wrap)        count_q <= (mode == MODE_CAPTURE) ? '0 : rc_q;
    else if (step)        count_q <= count_q + 1'b1;
  end

  // Reload/capture register: hardware capture wins over software write.
  always_ff @(posedge clk) begin
    if (rst)           rc_q <= '0;
    else if (cap_trig) rc_q <= count_q;
    else if (rc_wr_en) rc_q <= rc_wr_data;
  end

  // Sticky flags: set wins over clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag  <= 1'b0;
      ext_flag  <= 1'b0;
      baud_tick <= 1'b0;
    end else begin
      ovf_flag  <= ovf_evt | (ovf_flag & ~clr_ovf);
      ext_flag  <= ext_evt | (ext_flag & ~clr_ext);
      baud_tick <= wrap && (mode == MODE_BAUD);
    end
  end

  // R1: off mode leaves the count alone unless software writes it
  a_r1_off_holds: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF && !cnt_wr_en) |=> $stable(count_q));

  // R2: wrap in reload mode loads rc_q and flags overflow
  a_r2_reload_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RELOAD && src_tick && count_q == CNT_MAX && !cnt_wr_en && !trig_fall)
      |=> (count_q == $past(rc_q) && ovf_flag));

  // R5: capture copies the pre-edge count
  a_r5_capture_copy: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CAPTURE && cfg_ext_en && trig_fall) |=> (rc_q == $past(count_q)));

  // R6: baud mode never raises the overflow flag
  a_r6_baud_no_ovf: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_BAUD && !ovf_flag) |=> !ovf_flag);

  // R8: flags are sticky without a clear
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !clr_ovf) |=> ovf_flag);
  a_r8_ext_sticky: assert property (@(posedge clk) disable iff (rst)
    (ext_flag && !clr_ext) |=> ext_flag);

  // R9: software write lands regardless of counting
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_en |=> (count_q == $past(cnt_wr_data)));
endmodule

// File: tb/tb_tmr16_reload_capture.sv
module tb_tmr16_reload_capture;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct packed {
    logic         baud;
    logic         cap;
    logic         run;
    logic [W-1:0] cnt;
    logic         ovf;
  } vec_t;

  // Start 0xFFFE, rc 0x1234, three edges of core-clock counting.
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b0, 16'hFFFE, 1'b0},
    '{1'b0, 1'b0, 1'b1, 16'h1235, 1'b1},
    '{1'b0, 1'b1, 1'b0, 16'hFFFE, 1'b0},
    '{1'b0, 1'b1, 1'b1, 16'h0001, 1'b1},
    '{1'b1, 1'b0, 1'b0, 16'hFFFE, 1'b0},
    '{1'b1, 1'b0, 1'b1, 16'h1235, 1'b0},
    '{1'b1, 1'b1, 1'b0, 16'hFFFE, 1'b0},
    '{1'b1, 1'b1, 1'b1, 16'h1235, 1'b0}
  };

  logic clk = 0, rst = 1;
  logic cfg_run = 0, cfg_cap_sel = 0, cfg_baud_sel = 0, cfg_ext_en = 0, cfg_src_ext = 0;
  logic cnt_pin = 1, trig_pin = 1;
  logic cnt_wr_en = 0, rc_wr_en = 0, clr_ovf = 0, clr_ext = 0;
  logic [W-1:0] cnt_wr_data = '0, rc_wr_data = '0;
  logic [W-1:0] count_q, rc_q;
  logic ovf_flag, ext_flag, baud_tick;
  int checks = 0, failures = 0;
  bit done = 0;

  tmr16_reload_capture #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .cfg_run(cfg_run), .cfg_cap_sel(cfg_cap_sel),
    .cfg_baud_sel(cfg_baud_sel), .cfg_ext_en(cfg_ext_en), .cfg_src_ext(cfg_src_ext),
    .cnt_pin(cnt_pin), .trig_pin(trig_pin), .cnt_wr_en(cnt_wr_en),
    .cnt_wr_data(cnt_wr_data), .rc_wr_en(rc_wr_en), .rc_wr_data(rc_wr_data),
    .clr_ovf(clr_ovf), .clr_ext(clr_ext), .count_q(count_q), .rc_q(rc_q),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .baud_tick(baud_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write count and rc, clear flags, apply config; returns on the next falling edge.
  task automatic setup(input logic [W-1:0] c, input logic [W-1:0] r,
                       input logic b, input logic cp, input logic rn,
                       input logic ee, input logic se);
    @(negedge clk);
    cnt_wr_en = 1; cnt_wr_data = c; rc_wr_en = 1; rc_wr_data = r;
    clr_ovf = 1; clr_ext = 1;
    cfg_baud_sel = b; cfg_cap_sel = cp; cfg_run = rn; cfg_ext_en = ee; cfg_src_ext = se;
    @(negedge clk);
    cnt_wr_en = 0; rc_wr_en = 0; clr_ovf = 0; clr_ext = 0;
  endtask

  task automatic idle_pins();
    trig_pin = 1; cnt_pin = 1; cfg_run = 0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 count", count_q, 0);
    check("R10 rc", rc_q, 0);
    check("R10 flags", {ovf_flag, ext_flag, baud_tick}, 0);
    rst = 0;

    // R1 R2 R4 R6: mode decode table
    for (int i = 0; i < 8; i++) begin
      setup(16'hFFFE, 16'h1234, VECS[i].baud, VECS[i].cap, VECS[i].run, 1'b0, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check($sformatf("R1 vec%0d count", i), count_q, VECS[i].cnt);
      check($sformatf("R1 vec%0d ovf", i), ovf_flag, VECS[i].ovf);
    end
    idle_pins();

    // R3: trigger reload in auto-reload mode
    setup(16'h0100, 16'h5555, 0, 0, 1, 1, 0);
    trig_pin = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 reload count", count_q, 16'h5555);
    check("R3 ext flag", ext_flag, 1);
    check("R3 no ovf", ovf_flag, 0);
    idle_pins();

    // R3: trigger ignored with ext enable off
    setup(16'h0200, 16'h5555, 0, 0, 1, 0, 0);
    trig_pin = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 disabled count", count_q, 16'h0203);
    check("R3 disabled ext", ext_flag, 0);
    idle_pins();

    // R5: capture
    setup(16'h1000, 16'h0000, 0, 1, 1, 1, 0);
    trig_pin = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 captured", rc_q, 16'h1002);
    check("R5 count undisturbed", count_q, 16'h1003);
    check("R5 ext flag", ext_flag, 1);
    idle_pins();

    // R6: baud tick, trigger sets ext only
    setup(16'hFFFE, 16'hABCD, 1, 0, 1, 1, 0);
    trig_pin = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R6 tick high", baud_tick, 1);
    check("R6 reloaded", count_q, 16'hABCD);
    @(posedge clk);
    @(negedge clk);
    check("R6 tick one cycle", baud_tick, 0);
    check("R6 trigger no reload", count_q, 16'hABCE);
    check("R6 ext flag", ext_flag, 1);
    check("R6 no ovf", ovf_flag, 0);
    idle_pins();

    // R7: external count source
    setup(16'h0010, 16'h0000, 0, 0, 1, 0, 1);
    cnt_pin = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 latency hold", count_q, 16'h0010);
    @(posedge clk);
    @(negedge clk);
    check("R7 first edge", count_q, 16'h0011);
    cnt_pin = 1;
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); cnt_pin = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); cnt_pin = 1;
      repeat (3) @(posedge clk);
    end
    @(negedge clk);
    check("R7 five edges", count_q, 16'h0015);
    idle_pins();

    // R8: set wins over clear, sticky, then clear
    setup(16'hFFFE, 16'h0000, 0, 0, 1, 0, 0);
    @(posedge clk);
    @(negedge clk);
    clr_ovf = 1;
    @(posedge clk);
    @(negedge clk);
    check("R8 set beats clear", ovf_flag, 1);
    clr_ovf = 0; cfg_run = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 sticky", ovf_flag, 1);
    clr_ovf = 1;
    @(posedge clk);
    @(negedge clk);
    clr_ovf = 0;
    check("R8 cleared", ovf_flag, 0);
    idle_pins();

    // R9: software write beats increment
    setup(16'h0100, 16'h0000, 0, 0, 1, 0, 0);
    cnt_wr_en = 1; cnt_wr_data = 16'h7777;
    @(posedge clk);
    @(negedge clk);
    cnt_wr_en = 0;
    check("R9 write value", count_q, 16'h7777);
    @(posedge clk);
    @(negedge clk);
    check("R9 resumes", count_q, 16'h7778);
    idle_pins();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule